// File: doc/BRIEF.md
# Iterative AES-128/192/256 Encryption Round Engine

This block encrypts one 128-bit block with AES by reusing a single round datapath. It first adds round key 0 to the plaintext, then computes one full round per clock. The last round has no column mixing. The key length is fixed at build time and sets the round count Nr: 10, 12 or 14.

The key schedule lives outside the block. The engine drives a round-key index, and the surrounding logic returns the matching 128-bit round key on `round_key` in the same cycle, so the index also acts as the read address of the external key store. Work starts only when the caller signals that the input block is stable and the schedule signals that the expanded key is ready. If the key-ready flag drops during a block, the block is abandoned. A finished block is reported by a single-cycle pulse, and the ciphertext register keeps its value until the next completion.

Top module: `aes_round_engine`

## Requirements
- R1: While `rst_n` is low at a rising edge, and after that edge, `done` is 0, `key_index` is 0 and `cipher_out` is all zeros.
- R2: When the engine is idle, it leaves idle only at an edge where `data_stable` and `key_ready` are both 1. Either flag alone keeps `key_index` at 0 and produces no `done`.
- R3: The parameter `KEY_BITS` (128, 192 or 256) sets Nr = KEY_BITS/32 + 6. `done` is 0 for the first Nr+1 edges after the start edge and rises after edge Nr+2.
- R4: `key_index` is 0 during the key-addition cycle and rises by one each cycle up to Nr in the final round. It returns to 0 when the block completes.
- R5: `cipher_out` equals AES encryption of the plaintext, using the round key presented at index r as round key r. Byte 0 of a block or key is bits 127:120, and bytes fill the state column by column.
- R6: `done` is high for exactly one cycle, in the cycle `cipher_out` first shows the new result. `cipher_out` does not change in any cycle without `done`.
- R7: `key_ready` low in any busy cycle aborts the block. At the next edge `key_index` returns to 0, no `done` follows, and `cipher_out` keeps its earlier value.
- R8: `plain_in` is sampled only in the key-addition cycle, which follows the start edge. Changes on `plain_in` or `data_stable` while busy have no effect on the result or its timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset |
| data_stable | input | 1 | Input block is valid and held |
| key_ready | input | 1 | Expanded key schedule is usable |
| plain_in | input | 128 | Plaintext block |
| round_key | input | 128 | Round key for the current `key_index` |
| key_index | output | 4 | Round number and round-key address |
| cipher_out | output | 128 | Ciphertext register |
| done | output | 1 | One-cycle completion pulse |

## Verification
The bench builds three engines side by side, with KEY_BITS set to 128, 192 and 256. This covers all three round counts, and with them the last index 14 and the three completion latencies. Each engine gets round keys from a bench-side schedule. That schedule includes the extra substitution step that only 256-bit keys use, so known-answer vectors for every key length check the full round sequence of each build.

// File: rtl/aes_eng_pkg.sv
// Package: shared types, sizes and byte functions for the AES round engine.
// The substitution table is computed at elaboration time from the
// GF(2^8) inverse and the affine map; no table is written out.
package aes_eng_pkg;

    localparam int BLK_W      = 128;
    localparam int MAX_ROUNDS = 14;
    localparam int RK_IDX_W   = $clog2(MAX_ROUNDS + 1);

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_INIT,
        ST_ROUND,
        ST_FINAL,
        ST_DONE
    } eng_state_e;

    // Number of rounds for a key length in bits.
    function automatic int rounds_for(input int key_bits);
        return key_bits / 32 + 6;
    endfunction

    // Multiply by x in GF(2^8) with the AES polynomial.
    function automatic logic [7:0] gf_xtime(input logic [7:0] a);
        return {a[6:0], 1'b0} ^ (a[7] ? 8'h1b : 8'h00);
    endfunction

    // General GF(2^8) product by shift-and-add.
    function automatic logic [7:0] gf_mul(input logic [7:0] a, input logic [7:0] b);
        logic [7:0] acc;
        logic [7:0] sh;
        acc = 8'h00;
        sh  = a;
        for (int i = 0; i < 8; i++) begin
            if (b[i]) acc = acc ^ sh;
            sh = gf_xtime(sh);
        end
        return acc;
    endfunction

    // Inverse as a^254 (0 maps to 0).
    function automatic logic [7:0] gf_inv(input logic [7:0] a);
        logic [7:0] p;
        logic [7:0] r;
        p = a;
        r = 8'h01;
        for (int i = 1; i < 8; i++) begin
            p = gf_mul(p, p);
            r = gf_mul(r, p);
        end
        return r;
    endfunction

    // Builds all 256 substitution bytes, entry i at bits [8i+7:8i].
    function automatic logic [2047:0] build_sbox();
        logic [2047:0] tbl;
        logic [7:0]    v;
        tbl = '0;
        for (int i = 0; i < 256; i++) begin
            v = gf_inv(8'(i));
            tbl[i*8 +: 8] = v ^ {v[6:0], v[7]} ^ {v[5:0], v[7:6]}
                              ^ {v[4:0], v[7:5]} ^ {v[3:0], v[7:4]} ^ 8'h63;
        end
        return tbl;
    endfunction

    localparam logic [2047:0] SBOX_TBL = build_sbox();

    function automatic logic [7:0] sbox(input logic [7:0] b);
        return SBOX_TBL[{b, 3'b000} +: 8];
    endfunction

endpackage

// File: rtl/aes_sub_shift.sv
// Byte substitution followed by the row rotation, on one 128-bit state.
// Assumes byte k sits at bits [127-8k -: 8], row k%4, column k/4.
module aes_sub_shift
    import aes_eng_pkg::*;
(
    input  logic [BLK_W-1:0] st_in,
    output logic [BLK_W-1:0] st_out
);
    localparam int NBYTES = BLK_W / 8;

    // One substitution per output byte, taking its source after row rotation.
    for (genvar k = 0; k < NBYTES; k++) begin : g_byte
        localparam int ROW = k % 4;
        localparam int COL = k / 4;
        localparam int SRC = ROW + 4 * ((COL + ROW) % 4);
        assign st_out[BLK_W-1-8*k -: 8] = sbox(st_in[BLK_W-1-8*SRC -: 8]);
    end
endmodule

// File: rtl/aes_mix_columns.sv
// Column mixing: each 32-bit column is multiplied by the fixed circulant
// matrix (2 3 1 1). Purely combinational, no assumptions on timing.
module aes_mix_columns
    import aes_eng_pkg::*;
(
    input  logic [BLK_W-1:0] col_in,
    output logic [BLK_W-1:0] col_out
);
    localparam int NCOLS = BLK_W / 32;

    // One matrix product per column.
    for (genvar c = 0; c < NCOLS; c++) begin : g_col
        logic [7:0] a0, a1, a2, a3;
        logic [7:0] d0, d1, d2, d3;
        assign a0 = col_in[BLK_W-1-32*c      -: 8];
        assign a1 = col_in[BLK_W-1-32*c - 8  -: 8];
        assign a2 = col_in[BLK_W-1-32*c - 16 -: 8];
        assign a3 = col_in[BLK_W-1-32*c - 24 -: 8];
        assign d0 = gf_xtime(a0);
        assign d1 = gf_xtime(a1);
        assign d2 = gf_xtime(a2);
        assign d3 = gf_xtime(a3);
        assign col_out[BLK_W-1-32*c      -: 8] = d0 ^ d1 ^ a1 ^ a2 ^ a3;
        assign col_out[BLK_W-1-32*c - 8  -: 8] = a0 ^ d1 ^ d2 ^ a2 ^ a3;
        assign col_out[BLK_W-1-32*c - 16 -: 8] = a0 ^ a1 ^ d2 ^ d3 ^ a3;
        assign col_out[BLK_W-1-32*c - 24 -: 8] = d0 ^ a0 ^ a1 ^ a2 ^ d3;
    end
endmodule

// File: rtl/aes_round_ctrl.sv
// Round sequencer: idle -> key addition -> Nr-1 full rounds -> final round
// -> done. The round counter is the round-key address. Assumes key_ready
// stays high for the whole block; a low value aborts to idle.
module aes_round_ctrl
    import aes_eng_pkg::*;
#(
    parameter int NR = 10
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                data_stable,
    input  logic                key_ready,
    output logic [RK_IDX_W-1:0] rk_idx,
    output logic                ld_init,
    output logic                ld_round,
    output logic                ld_final,
    output logic                busy,
    output logic                done
);
    localparam logic [RK_IDX_W-1:0] LAST_MID = RK_IDX_W'(NR - 1);

    eng_state_e state_q;

    // State, index and completion pulse registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            rk_idx  <= '0;
            done    <= 1'b0;
        end else begin
            done <= 1'b0;
            case (state_q)
                ST_IDLE: begin
                    rk_idx <= '0;
                    if (data_stable && key_ready) state_q <= ST_INIT;
                end
                ST_INIT: begin
                    if (!key_ready) begin
                        state_q <= ST_IDLE;
                        rk_idx  <= '0;
                    end else begin
                        state_q <= ST_ROUND;
                        rk_idx  <= RK_IDX_W'(1);
                    end
                end
                ST_ROUND: begin
                    if (!key_ready) begin
                        state_q <= ST_IDLE;
                        rk_idx  <= '0;
                    end else begin
                        rk_idx <= rk_idx + RK_IDX_W'(1);
                        if (rk_idx == LAST_MID) state_q <= ST_FINAL;
                    end
                end
                ST_FINAL: begin
                    state_q <= key_ready ? ST_DONE : ST_IDLE;
                    rk_idx  <= '0;
                    done    <= key_ready;
                end
                default: begin
                    state_q <= ST_IDLE;
                    rk_idx  <= '0;
                end
            endcase
        end
    end

    // Datapath load strobes, gated by the key still being valid.
    always_comb begin
        busy     = (state_q == ST_INIT) || (state_q == ST_ROUND) || (state_q == ST_FINAL);
        ld_init  = (state_q == ST_INIT)  && key_ready;
        ld_round = (state_q == ST_ROUND) && key_ready;
        ld_final = (state_q == ST_FINAL) && key_ready;
    end
endmodule

// File: rtl/aes_round_engine.sv
// Iterative AES encryption of one block: key addition, then one round per
// clock using round keys fetched by index from an outside schedule.
// Assumes round_key reflects key_index combinationally in the same cycle
// and plain_in is held during the cycle after the start edge.
module aes_round_engine
    import aes_eng_pkg::*;
#(
    parameter int KEY_BITS = 128
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                data_stable,
    input  logic                key_ready,
    input  logic [BLK_W-1:0]    plain_in,
    input  logic [BLK_W-1:0]    round_key,
    output logic [RK_IDX_W-1:0] key_index,
    output logic [BLK_W-1:0]    cipher_out,
    output logic                done
);
    localparam int NR = rounds_for(KEY_BITS);

    logic             ld_init, ld_round, ld_final, busy;
    logic [BLK_W-1:0] st_q, ss_w, mc_w;

    aes_round_ctrl #(.NR(NR)) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .data_stable (data_stable),
        .key_ready   (key_ready),
        .rk_idx      (key_index),
        .ld_init     (ld_init),
        .ld_round    (ld_round),
        .ld_final    (ld_final),
        .busy        (busy),
        .done        (done)
    );

    aes_sub_shift u_subshift (
        .st_in  (st_q),
        .st_out (ss_w)
    );

    aes_mix_columns u_mix (
        .col_in  (ss_w),
        .col_out (mc_w)
    );

    // Working state: key addition first, then full rounds.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else if (ld_init) begin
            st_q <= plain_in ^ round_key;
        end else if (ld_round) begin
            st_q <= mc_w ^ round_key;
        end
    end

    // Ciphertext register, loaded only by the final round.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cipher_out <= '0;
        end else if (ld_final) begin
            cipher_out <= ss_w ^ round_key;
        end
    end
endmodule

// File: rtl/aes_round_engine_chk.sv
// Property checker for the round engine, attached by bind below.
// Observes ports plus the controller's busy flag.
module aes_round_engine_chk #(
    parameter int NR    = 10,
    parameter int IDX_W = 4,
    parameter int W     = 128
) (
    input logic             clk,
    input logic             rst_n,
    input logic             data_stable,
    input logic             key_ready,
    input logic             busy,
    input logic [IDX_W-1:0] key_index,
    input logic [W-1:0]     cipher_out,
    input logic             done
);
    localparam logic [IDX_W-1:0] NR_W = IDX_W'(NR);

    // R2: no start unless both flags are high
    a_r2_no_start: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !(data_stable && key_ready)) |=> !busy);

    // R3: completion follows the final-round index
    a_r3_done_after_final: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> ($past(key_index) == NR_W));

    // R4: index stays within the schedule
    a_r4_idx_range: assert property (@(posedge clk) disable iff (!rst_n)
        key_index <= NR_W);

    // R4: index steps by one while a block runs
    a_r4_idx_step: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && key_ready && key_index < NR_W) |=> (key_index == $past(key_index) + IDX_W'(1)));

    // R6: completion pulse lasts one cycle
    a_r6_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R6: ciphertext moves only together with done
    a_r6_cipher_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> $stable(cipher_out));

    // R7: key loss aborts without completion
    a_r7_abort: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !key_ready) |=> (key_index == '0 && !done));
endmodule

bind aes_round_engine aes_round_engine_chk #(
    .NR    (NR),
    .IDX_W (aes_eng_pkg::RK_IDX_W),
    .W     (aes_eng_pkg::BLK_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .data_stable (data_stable),
    .key_ready   (key_ready),
    .busy        (busy),
    .key_index   (key_index),
    .cipher_out  (cipher_out),
    .done        (done)
);

// File: tb/test_aes_round_engine.sv
`timescale 1ns/1ps
// Bench: three engines (128/192/256-bit keys) fed by bench-expanded round
// keys; known-answer vectors from a table, then directed corner cases.
module test_aes_round_engine;

    typedef struct packed {
        logic [1:0]   sel;
        logic [255:0] key;
        logic [127:0] pt;
        logic [127:0] ct;
    } vec_t;

    localparam int NVEC = 5;
    localparam vec_t VECS [NVEC] = '{
        '{2'd0, 256'h000102030405060708090a0b0c0d0e0f_00000000000000000000000000000000,
          128'h00112233445566778899aabbccddeeff, 128'h69c4e0d86a7b0430d8cdb78070b4c55a},
        '{2'd0, 256'h2b7e151628aed2a6abf7158809cf4f3c_00000000000000000000000000000000,
          128'h3243f6a8885a308d313198a2e0370734, 128'h3925841d02dc09fbdc118597196a0b32},
        '{2'd0, 256'h2b7e151628aed2a6abf7158809cf4f3c_00000000000000000000000000000000,
          128'h6bc1bee22e409f96e93d7e117393172a, 128'h3ad77bb40d7a3660a89ecaf32466ef97},
        '{2'd1, 256'h000102030405060708090a0b0c0d0e0f1011121314151617_0000000000000000,
          128'h00112233445566778899aabbccddeeff, 128'hdda97ca4864cdfe06eaf70a0ec0d7191},
        '{2'd2, 256'h000102030405060708090a0b0c0d0e0f101112131415161718191a1b1c1d1e1f,
          128'h00112233445566778899aabbccddeeff, 128'h8ea2b7ca516745bfeafc49904b496089}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #10 clk = ~clk;

    logic         ds    [3];
    logic         kr    [3];
    logic [127:0] pt_r  [3];
    logic [127:0] rk_w  [3];
    logic [3:0]   idx_w [3];
    logic [127:0] ct_w  [3];
    logic         done_w[3];
    logic [127:0] rkmem [3][15];
    logic [7:0]   bsb   [256];

    int checks = 0;
    int failures = 0;
    bit finished = 1'b0;

    for (genvar g = 0; g < 3; g++) begin : g_dut
        assign rk_w[g] = rkmem[g][idx_w[g]];
        aes_round_engine #(.KEY_BITS(128 + 64*g)) i_aes_round_engine (
            .clk         (clk),
            .rst_n       (rst_n),
            .data_stable (ds[g]),
            .key_ready   (kr[g]),
            .plain_in    (pt_r[g]),
            .round_key   (rk_w[g]),
            .key_index   (idx_w[g]),
            .cipher_out  (ct_w[g]),
            .done        (done_w[g])
        );
    end

    function automatic logic [7:0] b_xt(input logic [7:0] a);
        return a[7] ? ({a[6:0], 1'b0} ^ 8'h1b) : {a[6:0], 1'b0};
    endfunction

    function automatic logic [7:0] b_mul(input logic [7:0] a, input logic [7:0] b);
        logic [7:0] r;
        logic [7:0] x;
        r = 0;
        x = a;
        for (int i = 0; i < 8; i++) begin
            if (b[i]) r ^= x;
            x = b_xt(x);
        end
        return r;
    endfunction

    // Bench substitution table: inverse by search, affine map bit by bit.
    task automatic fill_sbox();
        for (int x = 0; x < 256; x++) begin
            logic [7:0] inv;
            logic [7:0] s;
            inv = 8'h00;
            for (int y = 1; y < 256; y++)
                if (b_mul(8'(x), 8'(y)) == 8'h01) inv = 8'(y);
            for (int i = 0; i < 8; i++)
                s[i] = inv[i] ^ inv[(i+4)%8] ^ inv[(i+5)%8] ^ inv[(i+6)%8]
                       ^ inv[(i+7)%8] ^ ((8'h63 >> i) & 8'h01) != 0;
            bsb[x] = s;
        end
    endtask

    function automatic logic [31:0] subw(input logic [31:0] w);
        return {bsb[w[31:24]], bsb[w[23:16]], bsb[w[15:8]], bsb[w[7:0]]};
    endfunction

    // Expands a key for engine g into its round-key memory.
    task automatic load_keys(input int g, input logic [255:0] key);
        logic [31:0] w [60];
        logic [31:0] t;
        logic [7:0]  rc;
        int nk;
        int nr;
        nk = 4 + 2*g;
        nr = 10 + 2*g;
        rc = 8'h01;
        for (int i = 0; i < nk; i++) w[i] = key[255-32*i -: 32];
        for (int i = nk; i < 4*(nr+1); i++) begin
            t = w[i-1];
            if (i % nk == 0) begin
                t = subw({t[23:0], t[31:24]}) ^ {rc, 24'h0};
                rc = b_xt(rc);
            end else if (nk > 6 && i % nk == 4) begin
                t = subw(t);
            end
            w[i] = w[i-nk] ^ t;
        end
        for (int r = 0; r < 15; r++)
            rkmem[g][r] = (r <= nr) ? {w[4*r], w[4*r+1], w[4*r+2], w[4*r+3]} : '0;
    endtask

    task automatic chk(input bit ok, input string req, input logic [127:0] act,
                       input logic [127:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic report();
        if (!finished) begin
            finished = 1'b1;
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    // Runs one block on engine g; optional disturbance while busy (R8).
    task automatic run_block(input int g, input logic [127:0] p, input logic [127:0] exp,
                             input bit disturb, input string tag);
        int nr;
        bit quiet;
        bit idx_ok;
        nr = 10 + 2*g;
        quiet = 1'b1;
        idx_ok = 1'b1;
        pt_r[g] = p;
        ds[g] = 1'b1;
        for (int k = 1; k <= nr + 1; k++) begin
            @(negedge clk);
            if (done_w[g] !== 1'b0) quiet = 1'b0;
            if (idx_w[g] !== 4'(k-1)) idx_ok = 1'b0;
            if (disturb && k == 3) begin
                pt_r[g] = ~p;
                ds[g] = 1'b0;
            end
            if (disturb && k == 4) ds[g] = 1'b1;
        end
        chk(quiet, {"R3 no early done ", tag}, 128'(done_w[g]), 128'd0);
        chk(idx_ok, {"R4 index sequence ", tag}, 128'(idx_w[g]), 128'(nr));
        @(negedge clk);
        chk(done_w[g] === 1'b1, {"R3 done at Nr+2 ", tag}, 128'(done_w[g]), 128'd1);
        chk(ct_w[g] === exp, {"R5 ciphertext ", tag}, ct_w[g], exp);
        chk(idx_w[g] === 4'd0, {"R4 index back to 0 ", tag}, 128'(idx_w[g]), 128'd0);
        ds[g] = 1'b0;
        pt_r[g] = '0;
        @(negedge clk);
        chk(done_w[g] === 1'b0, {"R6 single pulse ", tag}, 128'(done_w[g]), 128'd0);
        repeat (3) @(negedge clk);
        chk(ct_w[g] === exp, {"R6 ciphertext held ", tag}, ct_w[g], exp);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        failures++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        report();
    end

    initial begin
        for (int g = 0; g < 3; g++) begin
            ds[g] = 1'b0;
            kr[g] = 1'b1;
            pt_r[g] = '0;
            for (int r = 0; r < 15; r++) rkmem[g][r] = '0;
        end
        fill_sbox();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state on all three builds
        for (int g = 0; g < 3; g++) begin
            chk(done_w[g] === 1'b0, "R1 done after reset", 128'(done_w[g]), 128'd0);
            chk(idx_w[g] === 4'd0, "R1 index after reset", 128'(idx_w[g]), 128'd0);
            chk(ct_w[g] === '0, "R1 cipher after reset", ct_w[g], 128'd0);
        end

        // R5: known-answer table, one loop
        for (int v = 0; v < NVEC; v++) begin
            load_keys(int'(VECS[v].sel), VECS[v].key);
            run_block(int'(VECS[v].sel), VECS[v].pt, VECS[v].ct, 1'b0, $sformatf("vec%0d", v));
        end

        // R8: plaintext and data_stable changed while busy
        load_keys(0, VECS[0].key);
        run_block(0, VECS[0].pt, VECS[0].ct, 1'b1, "R8 busy disturbance");

        // R2: one start flag alone does nothing
        ds[1] = 1'b1;
        kr[1] = 1'b0;
        begin
            bit idle_ok;
            idle_ok = 1'b1;
            repeat (6) begin
                @(negedge clk);
                if (idx_w[1] !== 4'd0 || done_w[1] !== 1'b0) idle_ok = 1'b0;
            end
            ds[1] = 1'b0;
            kr[1] = 1'b1;
            repeat (20) begin
                @(negedge clk);
                if (idx_w[1] !== 4'd0 || done_w[1] !== 1'b0) idle_ok = 1'b0;
            end
            chk(idle_ok, "R2 no start on single flag", 128'(idx_w[1]), 128'd0);
            chk(ct_w[1] === VECS[3].ct, "R2 cipher untouched", ct_w[1], VECS[3].ct);
        end

        // R7: key loss mid-block aborts
        pt_r[2] = 128'hdeadbeef_00000000_cafef00d_12345678;
        ds[2] = 1'b1;
        repeat (5) @(negedge clk);
        kr[2] = 1'b0;
        @(negedge clk);
        chk(idx_w[2] === 4'd0, "R7 index cleared on abort", 128'(idx_w[2]), 128'd0);
        ds[2] = 1'b0;
        kr[2] = 1'b1;
        begin
            bit no_done;
            no_done = (done_w[2] === 1'b0);
            repeat (20) begin
                @(negedge clk);
                if (done_w[2] !== 1'b0) no_done = 1'b0;
            end
            chk(no_done, "R7 no done after abort", 128'(done_w[2]), 128'd0);
            chk(ct_w[2] === VECS[4].ct, "R7 cipher kept after abort", ct_w[2], VECS[4].ct);
        end
        run_block(2, VECS[4].pt, VECS[4].ct, 1'b0, "R7 recovery");

        report();
    end
endmodule